// File: doc/BRIEF.md
# Indirect PHY Control-Register Bridge

This block is a memory-mapped slave that gives a processor access to the 16-bit control registers inside a serial PHY through a narrow indirect window. Software loads a value into a staging register, then sets one of four strobe registers. The strobes capture the staged value as the PHY register address, capture it as write data, trigger a read, or trigger a write. Each strobe stays set while the PHY-side request is outstanding and clears itself when the PHY acknowledges.

A full write is five steps: stage the address, strobe address capture, stage the data, strobe data capture, strobe write. Software waits for each strobe to clear before the next step. A read stages and captures the address, then strobes a read and fetches the result from the read-result register. The PHY can return a stale value on the first read after an address capture. Software therefore issues the read strobe twice and keeps the second result. The bridge passes every returned value through unchanged. Per-lane PHY registers sit at a base address plus 0x100 times the lane number. Software abandons a strobe that has not cleared within about 100 microseconds.

Top module: `phyRegBridge`

## Requirements
- R1: After reset, the staging register, the read-result register and all four strobe bits read 0, and no PHY request is raised.
- R2: Writing a word with bit 0 set to a strobe register while no strobe is busy starts that operation. The register offsets are 0x14 address capture, 0x18 data capture, 0x1C read and 0x20 write. From the next cycle the strobe reads back 1 and the matching request is the only one high. The request bits are 0 address, 1 data, 2 read and 3 write.
- R3: A busy strobe and its request stay high until the acknowledge of the same operation is seen. Both drop one cycle after that acknowledge.
- R4: The staging register sits at offset 0x0C and holds 16 bits. Its value is driven on the PHY write-data port while a capture request is raised.
- R5: The read-result register sits at offset 0x10. It loads the PHY read data when a read is acknowledged and holds that value through all other operations.
- R6: While a strobe is busy, a new strobe write and a write to the staging register are both ignored.
- R7: An acknowledge for an operation other than the busy one does not clear the busy strobe.
- R8: Writing a word with bit 0 clear to a strobe register starts nothing.
- R9: After a full write sequence, the first read following an address capture returns whatever the PHY gives (possibly stale), and the second read returns the written value. Lane registers at different 0x100 offsets are kept apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Bus write enable for one cycle |
| busAddr | input | 6 | Bus byte offset |
| busWrData | input | 32 | Bus write data |
| busRdData | output | 32 | Bus read data for busAddr, combinational |
| phyReq | output | 4 | Request per operation: 0 address, 1 data, 2 read, 3 write |
| phyAck | input | 4 | Acknowledge per operation, same bit order |
| phyWrData | output | 16 | Staged value offered to the PHY |
| phyRdData | input | 16 | PHY read data, sampled on a read acknowledge |

## Verification
The hardest case to reach from the ports is a bus write that arrives while a strobe is outstanding, together with a stray acknowledge for a different operation. In normal use software always waits for the strobe to clear, so neither happens. The bench slows the PHY model's acknowledge latency to several cycles so that a window stays open. Inside that window it writes a second strobe, overwrites the staging register and forces a foreign acknowledge, then confirms that the busy strobe, the request and the offered data are all unchanged. A PHY model that returns a fixed stale word on the first read after each address capture exercises the double-read rule.

// File: rtl/phyRegBridgePkg.sv
package phyRegBridgePkg;
  localparam int ADDR_W  = 6;
  localparam int BUS_W   = 32;
  localparam int CR_W    = 16;
  localparam int NUM_OPS = 4;

  localparam logic [ADDR_W-1:0] OFF_DATA_IN  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_DATA_OUT = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_CAP_ADDR = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_CAP_DATA = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFF_RD_TRIG  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] OFF_WR_TRIG  = ADDR_W'(8'h20);

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_DATA  = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } crOp_e;

  typedef struct packed {
    logic  busy;
    crOp_e op;
    logic  rdDone;
  } ctrlStrb_t;
endpackage

// File: rtl/phyRegBridgeCtrl.sv
module phyRegBridgeCtrl
  import phyRegBridgePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busStartBit,
  input  logic [NUM_OPS-1:0] phyAck,
  output logic [NUM_OPS-1:0] phyReq,
  output ctrlStrb_t          strb
);
  logic  busy;
  crOp_e op;
  logic  hit;
  crOp_e hitOp;
  logic  start;
  logic  done;

  always_comb begin
    hit   = 1'b1;
    hitOp = OP_ADDR;
    case (busAddr)
      OFF_CAP_ADDR: hitOp = OP_ADDR;
      OFF_CAP_DATA: hitOp = OP_DATA;
      OFF_RD_TRIG:  hitOp = OP_READ;
      OFF_WR_TRIG:  hitOp = OP_WRITE;
      default:      hit   = 1'b0;
    endcase
  end

  assign start = busWrEn && busStartBit && hit && !busy;
  assign done  = busy && phyAck[op];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      op   <= OP_ADDR;
    end else if (done) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      op   <= hitOp;
    end
  end

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_req
    assign phyReq[k] = busy && (int'(op) == k);
  end

  assign strb.busy   = busy;
  assign strb.op     = op;
  assign strb.rdDone = done && (op == OP_READ);
endmodule

// File: rtl/phyRegBridgeData.sv
module phyRegBridgeData
  import phyRegBridgePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  ctrlStrb_t         strb,
  output logic [CR_W-1:0]   phyWrData,
  input  logic [CR_W-1:0]   phyRdData
);
  logic [CR_W-1:0] dataIn;
  logic [CR_W-1:0] dataOut;
  logic            unusedHigh;

  assign unusedHigh = ^busWrData[BUS_W-1:CR_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataIn  <= '0;
      dataOut <= '0;
    end else begin
      if (busWrEn && busAddr == OFF_DATA_IN && !strb.busy) dataIn <= busWrData[CR_W-1:0];
      if (strb.rdDone) dataOut <= phyRdData;
    end
  end

  always_comb begin
    case (busAddr)
      OFF_DATA_IN:  busRdData = BUS_W'(dataIn);
      OFF_DATA_OUT: busRdData = BUS_W'(dataOut);
      OFF_CAP_ADDR: busRdData = BUS_W'(strb.busy && strb.op == OP_ADDR);
      OFF_CAP_DATA: busRdData = BUS_W'(strb.busy && strb.op == OP_DATA);
      OFF_RD_TRIG:  busRdData = BUS_W'(strb.busy && strb.op == OP_READ);
      OFF_WR_TRIG:  busRdData = BUS_W'(strb.busy && strb.op == OP_WRITE);
      default:      busRdData = '0;
    endcase
  end

  assign phyWrData = dataIn;
endmodule

// File: rtl/phyRegBridge.sv
module phyRegBridge
  import phyRegBridgePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BUS_W-1:0]   busWrData,
  output logic [BUS_W-1:0]   busRdData,
  output logic [NUM_OPS-1:0] phyReq,
  input  logic [NUM_OPS-1:0] phyAck,
  output logic [CR_W-1:0]    phyWrData,
  input  logic [CR_W-1:0]    phyRdData
);
  ctrlStrb_t strb;

  phyRegBridgeCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busStartBit(busWrData[0]), .phyAck(phyAck), .phyReq(phyReq), .strb(strb)
  );

  phyRegBridgeData i_data (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .strb(strb),
    .phyWrData(phyWrData), .phyRdData(phyRdData)
  );
endmodule

// File: rtl/phyRegBridgeChecker.sv
module phyRegBridgeChecker
  import phyRegBridgePkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_OPS-1:0] phyReq,
  input logic [NUM_OPS-1:0] phyAck,
  input logic [CR_W-1:0]    phyWrData
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (phyReq == '0));

  assert_single_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(phyReq));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|(phyReq & ~phyAck)) |=> (phyReq == $past(phyReq)));

  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|(phyReq & phyAck)) |=> (phyReq == '0));

  assert_offer_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|(phyReq & ~phyAck)) |=> $stable(phyWrData));
endmodule

bind phyRegBridge phyRegBridgeChecker i_chk (.*);

// File: tb/test_phyRegBridge.sv
module test_phyRegBridge;
  import phyRegBridgePkg::*;

  localparam logic [CR_W-1:0] STALE = 16'h5A5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [BUS_W-1:0] busWrData = '0;
  logic [BUS_W-1:0] busRdData;
  logic [NUM_OPS-1:0] phyReq, phyAck, modelAck;
  logic [NUM_OPS-1:0] strayAck = '0;
  logic [CR_W-1:0] phyWrData, phyRdData;

  int nRun = 0;
  int nFail = 0;
  int lat = 3;
  logic [CR_W-1:0] expQ[$];
  logic [CR_W-1:0] obsQ[$];

  always #2 clk = ~clk;

  assign phyAck = modelAck | strayAck;

  phyRegBridge i_phyRegBridge (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .phyReq(phyReq),
    .phyAck(phyAck), .phyWrData(phyWrData), .phyRdData(phyRdData)
  );

  // PHY register-array model with a stale first read after address capture
  logic [CR_W-1:0] mem [32];
  logic [CR_W-1:0] curAddr, curData;
  logic firstRd;
  int cnt;

  function automatic int idx(logic [CR_W-1:0] a);
    return int'({a[8], a[3:0]});
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modelAck  <= '0;
      cnt       <= 0;
      firstRd   <= 1'b0;
      phyRdData <= '0;
      curAddr   <= '0;
      curData   <= '0;
      for (int i = 0; i < 32; i++) mem[i] <= '0;
    end else if (|modelAck) begin
      modelAck <= '0;
      cnt      <= 0;
    end else if (|phyReq) begin
      if (cnt + 1 >= lat) begin
        modelAck <= phyReq;
        cnt      <= 0;
        if (phyReq[0]) begin curAddr <= phyWrData; firstRd <= 1'b1; end
        if (phyReq[1]) curData <= phyWrData;
        if (phyReq[2]) begin
          phyRdData <= firstRd ? STALE : mem[idx(curAddr)];
          firstRd   <= 1'b0;
        end
        if (phyReq[3]) mem[idx(curAddr)] <= curData;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(string tag, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [BUS_W-1:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [ADDR_W-1:0] a, output logic [BUS_W-1:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic waitClear(logic [ADDR_W-1:0] a);
    logic [BUS_W-1:0] v;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      busRead(a, v);
      if (v[0] == 1'b0) return;
    end
    chk("R3 strobe never cleared", 32'd1, 32'd0);
  endtask

  task automatic crWrite(logic [CR_W-1:0] a, logic [CR_W-1:0] v);
    busWrite(OFF_DATA_IN, BUS_W'(a)); busWrite(OFF_CAP_ADDR, 1); waitClear(OFF_CAP_ADDR);
    busWrite(OFF_DATA_IN, BUS_W'(v)); busWrite(OFF_CAP_DATA, 1); waitClear(OFF_CAP_DATA);
    busWrite(OFF_WR_TRIG, 1); waitClear(OFF_WR_TRIG);
  endtask

  task automatic crReadTwice(logic [CR_W-1:0] a, logic [CR_W-1:0] v);
    logic [BUS_W-1:0] d;
    busWrite(OFF_DATA_IN, BUS_W'(a)); busWrite(OFF_CAP_ADDR, 1); waitClear(OFF_CAP_ADDR);
    expQ.push_back(STALE);
    busWrite(OFF_RD_TRIG, 1); waitClear(OFF_RD_TRIG);
    busRead(OFF_DATA_OUT, d); obsQ.push_back(d[CR_W-1:0]);
    expQ.push_back(v);
    busWrite(OFF_RD_TRIG, 1); waitClear(OFF_RD_TRIG);
    busRead(OFF_DATA_OUT, d); obsQ.push_back(d[CR_W-1:0]);
  endtask

  // monitor: compares every read result against the scoreboard (R5, R9)
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0 && expQ.size() > 0)
        chk("R9 read result", BUS_W'(obsQ.pop_front()), BUS_W'(expQ.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [BUS_W-1:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    busRead(OFF_DATA_IN, d);  chk("R1 data-in", d, 0);
    busRead(OFF_DATA_OUT, d); chk("R1 data-out", d, 0);
    busRead(OFF_CAP_ADDR, d); chk("R1 cap-addr", d, 0);
    busRead(OFF_CAP_DATA, d); chk("R1 cap-data", d, 0);
    busRead(OFF_RD_TRIG, d);  chk("R1 read", d, 0);
    busRead(OFF_WR_TRIG, d);  chk("R1 write", d, 0);
    chk("R1 req", BUS_W'(phyReq), 0);

    // R8 zero bit 0 starts nothing
    busWrite(OFF_WR_TRIG, 32'hFFFF_FFFE);
    busRead(OFF_WR_TRIG, d); chk("R8 strobe", d, 0);
    chk("R8 req", BUS_W'(phyReq), 0);

    // slow PHY: busy window for R2, R4, R6, R7
    lat = 8;
    busWrite(OFF_DATA_IN, 32'h0000_1006);
    busWrite(OFF_CAP_ADDR, 1);
    busRead(OFF_CAP_ADDR, d); chk("R2 strobe set", d, 1);
    chk("R2 req", BUS_W'(phyReq), 1);
    chk("R4 offered data", BUS_W'(phyWrData), 32'h1006);
    busWrite(OFF_RD_TRIG, 1);
    chk("R6 second strobe ignored", BUS_W'(phyReq), 1);
    busRead(OFF_RD_TRIG, d); chk("R6 read strobe", d, 0);
    busWrite(OFF_DATA_IN, 32'h0000_FFFF);
    busRead(OFF_DATA_IN, d); chk("R6 data-in held", d, 32'h1006);
    @(negedge clk); strayAck = 4'b0010;
    @(negedge clk); @(negedge clk); strayAck = 4'b0000;
    busRead(OFF_CAP_ADDR, d); chk("R7 foreign ack", d, 1);
    chk("R7 req", BUS_W'(phyReq), 1);
    waitClear(OFF_CAP_ADDR);
    chk("R3 req dropped", BUS_W'(phyReq), 0);

    // full sequences, lane 0 and lane 1
    lat = 2;
    crWrite(16'h1006, 16'hBEEF);
    crReadTwice(16'h1006, 16'hBEEF);
    lat = 5;
    crWrite(16'h1106, 16'h1234);
    crReadTwice(16'h1106, 16'h1234);
    lat = 1;
    crReadTwice(16'h1006, 16'hBEEF);

    // R5 data-out holds through non-read operations
    busWrite(OFF_DATA_IN, 32'h0000_0042); busWrite(OFF_CAP_DATA, 1); waitClear(OFF_CAP_DATA);
    busRead(OFF_DATA_OUT, d); chk("R5 data-out held", d, 32'hBEEF);

    repeat (4) @(negedge clk);
    chk("R9 scoreboard drained", BUS_W'(expQ.size() + obsQ.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule